// File: doc/BRIEF.md
# Diagnostic Test Output Selector with Bypass Dividers

This block drives a diagnostic `test_o` pin and the main clock output `fout_o` of a clock synthesizer. A 3-bit select code picks what appears on `test_o`. In the normal modes it can show the tail of the serial configuration shift register, a constant, the reference clock divided by 16, the feedback-counter output, the main output clock, or the main output clock divided by 4. In these modes `fout_o` passes the synthesizer's own output clock straight through.

One code selects bypass mode. There the serial configuration clock becomes the clock source for two dividers. The first is a programmable power-of-two divider, and it drives `fout_o`. The second is a feedback-style pulse counter, and its output appears on `test_o`. A board can then step the clock tree at low speed from the serial clock while debugging. Both bypass dividers clear themselves on every serial clock edge outside bypass mode, so each entry into bypass starts from a known phase.

The select mux is combinational. A new code takes effect on the next edge of the newly selected source. The block adds no glitch suppression.

Top module: `tos_test_sel`

## Requirements
- R1: With select code 000, `test_o` follows `sr_tail_i`, the serial shift-register tail, which changes in the serial clock domain.
- R2: Code 001 holds `test_o` at 1 and code 101 holds it at 0, whatever the clocks and other inputs do.
- R3: Code 010 shows a divide-by-16 of `ref_clk_i`. The divider is a free-running counter that starts at zero on reset. After k rising edges of `ref_clk_i`, `test_o` equals 1 exactly when (k mod 16) >= 8, giving a 50% duty cycle.
- R4: Code 011 routes `mcnt_i` to `test_o`, and code 100 routes `fout_i` to `test_o`.
- R5: Code 111 shows a divide-by-4 of `fout_i`. The divider starts at zero on reset. After k rising edges of `fout_i`, `test_o` equals 1 exactly when (k mod 4) >= 2.
- R6: For every code other than 110, `fout_o` equals `fout_i`.
- R7: With code 110 (bypass), `fout_o` divides `sclk_i` by 2^(n+1), where n is `n_i` (0..3). After j serial clock edges in bypass, `fout_o` equals bit n of j.
- R8: In bypass, `test_o` carries a pulse one serial clock period wide. The pulse follows every m-th serial clock edge, where m is `m_i`, and an `m_i` of 0 acts as 1. After j edges, `test_o` equals 1 exactly when j mod m = 0.
- R9: Every serial clock edge outside bypass clears both bypass dividers. On re-entry to bypass, before the first serial clock edge, `fout_o` and `test_o` are both 0.
- R10: While `rst_ni` is low, all divider state is zero, so codes 010, 111 and 110 all show 0 on `test_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock feeding the divide-by-16 |
| sclk_i | input | 1 | Serial configuration clock, the bypass clock source |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tsel_i | input | 3 | Test select code |
| m_i | input | 9 | Feedback count used by the bypass pulse counter |
| n_i | input | 2 | Output divider code used in bypass |
| sr_tail_i | input | 1 | Serial shift-register tail bit |
| mcnt_i | input | 1 | Normal-mode feedback-counter output |
| fout_i | input | 1 | Normal-mode synthesizer output clock |
| test_o | output | 1 | Diagnostic output |
| fout_o | output | 1 | Main clock output |

## Verification
The bench checks the bypass pulse counter at m = 0, m = 1 and larger counts. A counter that mishandles a zero count would stall or pulse at the wrong period. It also checks each of the four output divide codes, where a wrong bit pick would show twice or half the expected period. It leaves bypass partway through a divide period and then re-enters, so a design that does not clear on the non-bypass edge would resume mid-count instead of from zero. The two free-running dividers are checked edge by edge from reset release, so an off-by-one start or a duty cycle other than 50% shows up at once.

// File: rtl/tos_pkg.sv
`timescale 1ns/1ps
package tos_pkg;
  localparam int M_W = 9;
  localparam int N_W = 2;
  localparam int REF_STAGES  = 4;  // divide by 16
  localparam int FOUT_STAGES = 2;  // divide by 4

  typedef enum logic [2:0] {
    TSEL_SHIFT   = 3'b000,
    TSEL_ONE     = 3'b001,
    TSEL_REFDIV  = 3'b010,
    TSEL_MCNT    = 3'b011,
    TSEL_FOUT    = 3'b100,
    TSEL_ZERO    = 3'b101,
    TSEL_BYPASS  = 3'b110,
    TSEL_FOUTDIV = 3'b111
  } tsel_e;
endpackage

// File: rtl/tos_pow2_div.sv
`timescale 1ns/1ps
module tos_pow2_div #(
  parameter int STAGES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic div_o
);
  logic [STAGES-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign div_o = cnt_q[STAGES-1];
endmodule

// File: rtl/tos_bypass_ndiv.sv
`timescale 1ns/1ps
module tos_bypass_ndiv #(
  parameter int N_W = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [N_W-1:0] n_i,
  output logic           div_o
);
  localparam int CNT_W = 1 << N_W;

  logic [CNT_W-1:0] cnt_q;

  // cleared on every edge outside bypass so re-entry starts at phase zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign div_o = cnt_q[n_i];
endmodule

// File: rtl/tos_mpulse.sv
`timescale 1ns/1ps
module tos_mpulse #(
  parameter int M_W = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [M_W-1:0] m_i,
  output logic           pulse_o
);
  logic [M_W-1:0] cnt_q;
  logic [M_W-1:0] last;
  logic           pulse_q;

  // m of zero acts as one
  assign last = (m_i == '0) ? '0 : m_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (cnt_q >= last) begin
      cnt_q   <= '0;
      pulse_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/tos_test_sel.sv
`timescale 1ns/1ps
module tos_test_sel
  import tos_pkg::*;
(
  input  logic           ref_clk_i,
  input  logic           sclk_i,
  input  logic           rst_ni,
  input  logic [2:0]     tsel_i,
  input  logic [M_W-1:0] m_i,
  input  logic [N_W-1:0] n_i,
  input  logic           sr_tail_i,
  input  logic           mcnt_i,
  input  logic           fout_i,
  output logic           test_o,
  output logic           fout_o
);
  tsel_e tsel;
  logic  bypass;
  logic  ref_div, fout_div, byp_fout, byp_mpulse;

  assign tsel   = tsel_e'(tsel_i);
  assign bypass = (tsel == TSEL_BYPASS);

  tos_pow2_div #(.STAGES(REF_STAGES)) u_ref_div (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .div_o (ref_div)
  );

  tos_pow2_div #(.STAGES(FOUT_STAGES)) u_fout_div (
    .clk_i (fout_i),
    .rst_ni(rst_ni),
    .div_o (fout_div)
  );

  tos_bypass_ndiv #(.N_W(N_W)) u_byp_ndiv (
    .clk_i (sclk_i),
    .rst_ni(rst_ni),
    .en_i  (bypass),
    .n_i   (n_i),
    .div_o (byp_fout)
  );

  tos_mpulse #(.M_W(M_W)) u_byp_mcnt (
    .clk_i  (sclk_i),
    .rst_ni (rst_ni),
    .en_i   (bypass),
    .m_i    (m_i),
    .pulse_o(byp_mpulse)
  );

  always_comb begin
    unique case (tsel)
      TSEL_SHIFT:   test_o = sr_tail_i;
      TSEL_ONE:     test_o = 1'b1;
      TSEL_REFDIV:  test_o = ref_div;
      TSEL_MCNT:    test_o = mcnt_i;
      TSEL_FOUT:    test_o = fout_i;
      TSEL_ZERO:    test_o = 1'b0;
      TSEL_BYPASS:  test_o = byp_mpulse;
      TSEL_FOUTDIV: test_o = fout_div;
      default:      test_o = 1'b0;
    endcase
  end

  assign fout_o = bypass ? byp_fout : fout_i;
endmodule

// File: rtl/tos_test_sel_chk.sv
`timescale 1ns/1ps
module tos_test_sel_chk
  import tos_pkg::*;
(
  input logic           ref_clk_i,
  input logic           sclk_i,
  input logic           rst_ni,
  input logic [2:0]     tsel_i,
  input logic [M_W-1:0] m_i,
  input logic [N_W-1:0] n_i,
  input logic           test_o,
  input logic           fout_o
);
  logic                  byp;
  logic [REF_STAGES-1:0] ref_edges_q;

  assign byp = (tsel_i == 3'b110);

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_edges_q <= '0;
    else         ref_edges_q <= ref_edges_q + 1'b1;
  end

  assert_const_zero_R2: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (tsel_i == 3'b101) |-> !test_o);

  assert_refdiv_phase_R3: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (tsel_i == 3'b010) |-> (test_o == ref_edges_q[REF_STAGES-1]));

  assert_ndiv1_toggle_R7: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (byp && $past(byp) && n_i == '0 && $stable(n_i)) |-> (fout_o != $past(fout_o)));

  assert_mpulse_narrow_R8: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (byp && $past(byp) && m_i > 1 && $stable(m_i)) |-> !(test_o && $past(test_o)));

  assert_reentry_clear_R9: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (byp && !$past(byp)) |-> (!fout_o && !test_o));
endmodule

bind tos_test_sel tos_test_sel_chk u_chk (
  .ref_clk_i(ref_clk_i),
  .sclk_i   (sclk_i),
  .rst_ni   (rst_ni),
  .tsel_i   (tsel_i),
  .m_i      (m_i),
  .n_i      (n_i),
  .test_o   (test_o),
  .fout_o   (fout_o)
);

// File: tb/tos_test_sel_bench.sv
`timescale 1ns/1ps
module tos_test_sel_bench;
  logic       ref_clk = 1'b0;
  logic       sclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] tsel = 3'b000;
  logic [8:0] m_val = '0;
  logic [1:0] n_val = '0;
  logic       sr_tail = 1'b0;
  logic       mcnt = 1'b0;
  logic       fout_in = 1'b0;
  logic       test_out, fout_out;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 ref_clk = ~ref_clk;

  tos_test_sel u_tos_test_sel (
    .ref_clk_i(ref_clk),
    .sclk_i   (sclk),
    .rst_ni   (rst_n),
    .tsel_i   (tsel),
    .m_i      (m_val),
    .n_i      (n_val),
    .sr_tail_i(sr_tail),
    .mcnt_i   (mcnt),
    .fout_i   (fout_in),
    .test_o   (test_out),
    .fout_o   (fout_out)
  );

  // {tsel, sr_tail, mcnt, fout_in, exp_test, exp_fout}
  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{
    {3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R1, R6
    {3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R1, R6
    {3'b001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R2
    {3'b101, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},  // R2
    {3'b011, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R4
    {3'b011, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},  // R4
    {3'b100, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R4
    {3'b100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}   // R4
  };

  function automatic string req_of(input logic [2:0] t);
    case (t)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b101:  return "R2";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1; #3;
    sclk = 1'b0; #3;
  endtask

  task automatic fout_pulse();
    fout_in = 1'b1; #4;
    fout_in = 1'b0; #4;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge ref_clk);
    rst_n = 1'b1;
  endtask

  // R7, R8, R9: leave bypass, clear with one edge, re-enter, then step
  task automatic run_bypass(input int m, input int n, input int edges);
    int meff;
    meff = (m == 0) ? 1 : m;
    tsel = 3'b000;
    #1 sclk_pulse();
    m_val = 9'(m);
    n_val = 2'(n);
    tsel  = 3'b110;
    #1;
    check(fout_out, 1'b0, "R9 fout on re-entry");
    check(test_out, 1'b0, "R9 test on re-entry");
    for (int j = 1; j <= edges; j++) begin
      sclk_pulse();
      check(fout_out, 1'((j >> n) & 1), "R7 bypass divider");
      check(test_out, 1'((j % meff) == 0), "R8 bypass pulse");
    end
  endtask

  initial begin
    #500us;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R10: reset state of every divider
    tsel = 3'b010;
    #12;
    check(test_out, 1'b0, "R10 refdiv in reset");
    tsel = 3'b111;
    fout_pulse();
    check(test_out, 1'b0, "R10 foutdiv in reset");
    tsel = 3'b110;
    sclk_pulse();
    check(test_out, 1'b0, "R10 mpulse in reset");
    check(fout_out, 1'b0, "R10 ndiv in reset");

    // static routing table
    for (int i = 0; i < NV; i++) begin
      logic [2:0] t;
      logic tl, mc, fo, et, ef;
      {t, tl, mc, fo, et, ef} = VEC[i];
      tsel = t; sr_tail = tl; mcnt = mc; fout_in = fo;
      #1;
      check(test_out, et, req_of(t));
      check(fout_out, ef, "R6 fout passthrough");
    end
    fout_in = 1'b0;

    do_reset();

    // R3: divide by 16 from reset release
    tsel = 3'b010;
    for (int k = 1; k <= 40; k++) begin
      @(posedge ref_clk);
      @(negedge ref_clk);
      check(test_out, 1'((k % 16) >= 8), "R3 refdiv phase");
    end

    // R5: divide by 4 of fout_i
    do_reset();
    tsel = 3'b111;
    for (int k = 1; k <= 12; k++) begin
      fout_pulse();
      check(test_out, 1'((k % 4) >= 2), "R5 foutdiv phase");
    end

    // R7/R8/R9 bypass variants, including m=0 and m=1
    do_reset();
    run_bypass(5, 1, 12);
    run_bypass(0, 0, 6);
    run_bypass(1, 2, 10);
    run_bypass(3, 3, 20);
    run_bypass(7, 0, 3);   // exits mid-period before next run
    run_bypass(2, 1, 8);

    // R6 after bypass exit
    tsel = 3'b000;
    fout_in = 1'b1;
    #1 check(fout_out, 1'b1, "R6 fout after bypass");
    fout_in = 1'b0;
    #1 check(fout_out, 1'b0, "R6 fout after bypass");

    // R2: constants hold while clocks run
    tsel = 3'b001;
    sclk_pulse(); fout_pulse();
    check(test_out, 1'b1, "R2 const one");
    tsel = 3'b101;
    sclk_pulse(); fout_pulse();
    check(test_out, 1'b0, "R2 const zero");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule